// File: doc/BRIEF.md
# SPI Slave Peripheral with Maskable Interrupts

This block lets an external SPI master exchange bytes with a local processor. The serial clock, chip select and data input are brought into the system clock domain through two-flop synchronisers, so every edge is detected and acted on in that domain. The system clock must run at least four times faster than the serial clock. Received bytes go into a small receive queue. Bytes the processor writes are queued for transmission on the serial data output.

The processor reaches the block through a byte-wide register port with three locations. One holds the configuration: enable, clock phase, clock polarity, bit order and four interrupt masks. One reports status: queue readiness and sticky chip-select edge events. The third is the data port: a write queues a byte for transmission and a read takes the oldest received byte. A single interrupt line is raised while any unmasked status source is active.

Top module: `spi_slave_irq`

## Requirements
- R1: After reset, the configuration reads 0xF0, the status reads 0x02, `irq_o` is 0 and `miso_o` is 0.
- R2: Register map by `reg_addr`:
  - 0 is configuration (read/write). Its bits are: bit 0 enable, bit 1 clock phase, bit 2 clock polarity, bit 3 bit order, bit 4 receive-ready mask, bit 5 transmit-ready mask, bit 6 chip-select-high mask, bit 7 chip-select-low mask.
  - 1 is status (read).
  - 2 is data: a write queues a transmit byte and a read pops a received byte. A read of data while nothing is received returns 0x00.
  - Address 3 reads 0x00.
- R3: All four SPI timing modes work:
  - Clock polarity 0 idles the clock low. Clock polarity 1 idles it high.
  - With clock phase 0, the slave samples on the leading edge and changes its output on the trailing edge.
  - With clock phase 1, it changes its output on the leading edge and samples on the trailing edge.
- R4: Bit order 1 moves bytes LSB first and bit order 0 moves them MSB first. The setting applies to both the input and the output line.
- R5: The receive queue holds two bytes. A byte completed while the queue is full is dropped.
- R6: The transmit queue holds two bytes. A data write while it is full is dropped. When no byte is queued at the start of a byte slot, 0x00 is sent.
- R7: With enable at 0, bus activity has no effect:
  - No byte is received.
  - No chip-select event is recorded.
  - `miso_o` stays 0.
- R8: Status bits:
  - Bit 0 is receive data available.
  - Bit 1 is transmit location free.
  - Bit 2 is set on a chip-select rising edge.
  - Bit 3 is set on a chip-select falling edge.
  - Bits 2 and 3 are cleared by a read of the status register.
- R9: `irq_o` is the OR of status bits 0 to 3, each gated by its mask (configuration bits 4 to 7). A mask value of 1 blocks that source.
- R10: Raising chip select in the middle of a byte discards the partial byte. Each transaction starts at bit 0 of a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from master |
| csn_i | input | 1 | Active-low chip select from master |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data, clears events) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current address |
| irq_o | output | 1 | Combined interrupt |

## Verification
The in-RTL assertions check several properties on every cycle:
- The queue occupancy never exceeds its depth.
- A push into a full queue leaves it full.
- The bit counter returns to zero after each completed byte and while chip select is high.
- A status read clears the rising-edge event.
- Writing a configuration with every mask set silences the interrupt.

Other behaviours can only be shown by the bench's transactions against its scoreboard queues:
- The serial data order in each of the four timing modes.
- Bit-order reversal on both lines.
- Dropping of overflow bytes and 0x00 fill on an empty transmit queue.
- Discarding of a partial byte.
- Total silence while disabled.

// File: rtl/spis_pkg.sv
package spis_pkg;

  localparam int unsigned SPIS_DW = 8;

  typedef logic [SPIS_DW-1:0] spis_byte_t;

  // configuration register layout, MSB first
  typedef struct packed {
    logic [3:0] mask;   // [0] rx ready, [1] tx ready, [2] cs high, [3] cs low
    logic       lsb;
    logic       cpol;
    logic       cpha;
    logic       en;
  } spis_cfg_t;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } spis_addr_e;

  localparam spis_cfg_t CFG_RESET = '{mask: 4'hF, lsb: 1'b0, cpol: 1'b0, cpha: 1'b0, en: 1'b0};

  // position inside a byte of the idx-th bit on the wire
  function automatic logic [2:0] bit_pos(input logic [2:0] idx, input logic lsb_first);
    return lsb_first ? idx : (3'd7 - idx);
  endfunction

  // accumulate one received bit into the shift register
  function automatic spis_byte_t shift_in(input spis_byte_t sh, input logic b, input logic lsb_first);
    return lsb_first ? {b, sh[SPIS_DW-1:1]} : {sh[SPIS_DW-2:0], b};
  endfunction

  // combined interrupt from sources and masks
  function automatic logic irq_of(input logic [3:0] src, input logic [3:0] mask);
    return |(src & ~mask);
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[g]}};
      else        st <= {st[0], d[g]};
    end
    assign q[g] = st[1];
  end

endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  // R5
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));

  // R6
  fifo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

endmodule

// File: rtl/spis_core.sv
module spis_core
  import spis_pkg::*;
#(
  parameter int unsigned DW = SPIS_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          lsb_i,
  input  logic          sck_s,
  input  logic          csn_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_head,
  input  logic          tx_empty,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_byte,
  output logic          miso,
  output logic          cs_rise,
  output logic          cs_fall
);

  localparam int unsigned CNTW = $clog2(DW);
  localparam logic [CNTW-1:0] LASTBIT = CNTW'(DW - 1);

  logic            sck_q, csn_q;
  logic [CNTW-1:0] rcnt, ocnt;
  logic [DW-1:0]   rx_sh, cur, head_or_zero, sel_byte;
  logic            have_cur, first_shift;

  // named internal events
  logic active, sck_rise, sck_fall, lead_evt, trail_evt;
  logic sample_evt, shift_evt, load_cur, byte_done;

  assign active     = en_i && !csn_s;
  assign sck_rise   = sck_s && !sck_q;
  assign sck_fall   = !sck_s && sck_q;
  assign lead_evt   = active && (cpol_i ? sck_fall : sck_rise);
  assign trail_evt  = active && (cpol_i ? sck_rise : sck_fall);
  assign sample_evt = cpha_i ? trail_evt : lead_evt;
  assign shift_evt  = cpha_i ? lead_evt : trail_evt;
  assign cs_fall    = en_i && csn_q && !csn_s;
  assign cs_rise    = en_i && !csn_q && csn_s;

  assign load_cur     = (rcnt == '0) && !have_cur;
  assign byte_done    = sample_evt && (rcnt == LASTBIT);
  assign head_or_zero = tx_empty ? '0 : tx_head;
  assign sel_byte     = have_cur ? cur : head_or_zero;

  assign tx_pop  = sample_evt && load_cur && !tx_empty;
  assign rx_push = byte_done;
  assign rx_byte = shift_in(rx_sh, mosi_s, lsb_i);
  assign miso    = active ? sel_byte[bit_pos(ocnt, lsb_i)] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q       <= 1'b0;
      csn_q       <= 1'b1;
      rcnt        <= '0;
      ocnt        <= '0;
      have_cur    <= 1'b0;
      first_shift <= 1'b1;
      rx_sh       <= '0;
      cur         <= '0;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
      if (!active) begin
        rcnt        <= '0;
        ocnt        <= '0;
        have_cur    <= 1'b0;
        first_shift <= 1'b1;
      end else begin
        if (sample_evt) begin
          rx_sh <= rx_byte;
          rcnt  <= rcnt + CNTW'(1);
          if (load_cur) begin
            cur      <= head_or_zero;
            have_cur <= 1'b1;
          end
        end
        if (shift_evt) begin
          if (cpha_i && first_shift) begin
            first_shift <= 1'b0;
          end else begin
            ocnt <= ocnt + CNTW'(1);
            if (ocnt == LASTBIT) have_cur <= 1'b0;
          end
        end
      end
    end
  end

  // R10
  rcnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) csn_s |=> (rcnt == '0));

  // R3
  byte_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) byte_done |=> (rcnt == '0));

endmodule

// File: rtl/spi_slave_irq.sv
module spi_slave_irq
  import spis_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 2,
  parameter int unsigned TX_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o
);

  spis_cfg_t  cfg_q;
  logic [2:0] pins_s;
  logic       sck_s, csn_s, mosi_s;
  logic       flag_hi, flag_lo;
  spis_byte_t tx_head, rx_head, rx_byte;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic       tx_pop, rx_push, cs_rise, cs_fall;
  logic       cfg_wr, tx_push, rx_pop, stat_rd;
  logic [7:0] status;

  spis_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mosi_i, csn_i, sck_i}),
    .q(pins_s)
  );
  assign sck_s  = pins_s[0];
  assign csn_s  = pins_s[1];
  assign mosi_s = pins_s[2];

  assign cfg_wr  = reg_wr && (reg_addr == ADDR_CFG);
  assign tx_push = reg_wr && (reg_addr == ADDR_DATA);
  assign rx_pop  = reg_rd && (reg_addr == ADDR_DATA);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

  spis_core #(.DW(SPIS_DW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .en_i(cfg_q.en), .cpol_i(cfg_q.cpol), .cpha_i(cfg_q.cpha), .lsb_i(cfg_q.lsb),
    .sck_s(sck_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .miso(miso_o),
    .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  spis_fifo #(.DW(SPIS_DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
    .head(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spis_fifo #(.DW(SPIS_DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
    .head(rx_head), .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= spis_cfg_t'(reg_wdata);
      if (cs_rise)      flag_hi <= 1'b1;
      else if (stat_rd) flag_hi <= 1'b0;
      if (cs_fall)      flag_lo <= 1'b1;
      else if (stat_rd) flag_lo <= 1'b0;
    end
  end

  assign status = {4'b0000, flag_lo, flag_hi, !tx_full, !rx_empty};
  assign irq_o  = irq_of(status[3:0], cfg_q.mask);

  always_comb begin
    unique case (spis_addr_e'(reg_addr))
      ADDR_CFG:  reg_rdata = cfg_q;
      ADDR_STAT: reg_rdata = status;
      ADDR_DATA: reg_rdata = rx_empty ? 8'h00 : rx_head;
      default:   reg_rdata = 8'h00;
    endcase
  end

  // R8
  cs_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cs_rise) |=> !flag_hi);

  // R9
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (reg_wdata[7:4] == 4'hF)) |=> !irq_o);

  // R5
  rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_pop) |=> rx_full);

endmodule

// File: tb/test_spi_slave_irq.sv
`timescale 1ns/1ps
module test_spi_slave_irq;

  localparam int H = 8;  // system clocks per SCK half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, irq;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;

  int vec = 0, bad = 0;
  logic [7:0] miso_exp[$];
  logic [7:0] rx_exp[$];

  always #2 clk = ~clk;

  spi_slave_irq i_spi_slave_irq (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // monitor side: read received bytes and compare with the scoreboard
  task automatic drain_rx(string req, int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      reg_read(2'd2, d);
      chk(req, d, (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'h00);
    end
  endtask

  // one serial bit as master; returns the bit seen on miso
  task automatic one_bit(logic b, logic cpol, logic cpha, output logic m);
    if (!cpha) begin
      mosi = b; waitc(H);
      m = miso; sck = ~cpol; waitc(H);
      sck = cpol;
    end else begin
      sck = ~cpol; mosi = b; waitc(H);
      m = miso; sck = cpol; waitc(H);
    end
  endtask

  // driver + monitor: full transaction, miso bytes compared to miso_exp
  task automatic xfer(logic [7:0] mo [4], int n, logic cpol, logic cpha, logic lsb, string req);
    logic m;
    logic [7:0] got;
    sck = cpol; waitc(H);
    csn = 1'b0; waitc(H);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int i = 0; i < 8; i++) begin
        one_bit(mo[k][lsb ? i : 7 - i], cpol, cpha, m);
        got[lsb ? i : 7 - i] = m;
      end
      chk(req, got, (miso_exp.size() > 0) ? miso_exp.pop_front() : 8'h00);
    end
    waitc(H); csn = 1'b1; waitc(2 * H + 4);
  endtask

  task automatic mode_run(logic [7:0] cfg, logic cpol, logic cpha, logic lsb,
                          logic [7:0] t0, logic [7:0] t1, logic [7:0] r0, logic [7:0] r1, string req);
    logic [7:0] mo [4];
    mo = '{r0, r1, 8'h00, 8'h00};
    reg_write(2'd0, cfg);
    reg_write(2'd2, t0); reg_write(2'd2, t1);
    miso_exp.push_back(t0); miso_exp.push_back(t1);
    rx_exp.push_back(r0);   rx_exp.push_back(r1);
    xfer(mo, 2, cpol, cpha, lsb, req);
    drain_rx(req, 2);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] mo [4];
    logic m;
    waitc(4); rst_n = 1'b1; waitc(2);

    // R1 reset state
    reg_read(2'd0, d); chk("R1 cfg", d, 8'hF0);
    reg_read(2'd1, d); chk("R1 status", d, 8'h02);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 miso", {7'd0, miso}, 8'h00);

    // R2 register access
    reg_write(2'd0, 8'hF1); reg_read(2'd0, d); chk("R2 cfg readback", d, 8'hF1);
    reg_read(2'd2, d); chk("R2 empty data read", d, 8'h00);
    reg_read(2'd3, d); chk("R2 unused address", d, 8'h00);

    // R3 all four modes, MSB first
    mode_run(8'hF1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'h81, 8'h7E, "R3 mode0");
    mode_run(8'hF3, 1'b0, 1'b1, 1'b0, 8'h5A, 8'hC3, 8'h12, 8'hED, "R3 mode1");
    mode_run(8'hF5, 1'b1, 1'b0, 1'b0, 8'h96, 8'h0F, 8'h69, 8'hF0, "R3 mode2");
    mode_run(8'hF7, 1'b1, 1'b1, 1'b0, 8'h01, 8'hFE, 8'hB4, 8'h4B, "R3 mode3");

    // R4 LSB first on both lines
    mode_run(8'hF9, 1'b0, 1'b0, 1'b1, 8'h01, 8'hC8, 8'hC4, 8'h23, "R4 lsb mode0");
    mode_run(8'hFF, 1'b1, 1'b1, 1'b1, 8'h80, 8'h35, 8'h0E, 8'h71, "R4 lsb mode3");

    // R5 + R6: three bytes, empty tx queue, rx overflow drops third
    reg_write(2'd0, 8'hF1);
    mo = '{8'h11, 8'h22, 8'h33, 8'h00};
    repeat (3) miso_exp.push_back(8'h00);
    rx_exp.push_back(8'h11); rx_exp.push_back(8'h22);
    xfer(mo, 3, 1'b0, 1'b0, 1'b0, "R6 empty tx sends zero");
    drain_rx("R5 rx overflow", 3);

    // R6: write while tx queue full is dropped
    reg_read(2'd1, d);
    reg_write(2'd2, 8'hAA); reg_write(2'd2, 8'hBB); reg_write(2'd2, 8'hCC);
    reg_read(2'd1, d); chk("R6 tx full status", d, 8'h00);
    mo = '{8'h44, 8'h55, 8'h66, 8'h00};
    miso_exp.push_back(8'hAA); miso_exp.push_back(8'hBB); miso_exp.push_back(8'h00);
    rx_exp.push_back(8'h44); rx_exp.push_back(8'h55);
    xfer(mo, 3, 1'b0, 1'b0, 1'b0, "R6 dropped write");
    drain_rx("R6 rx after", 2);

    // R8 chip-select events, cleared by status read
    reg_read(2'd1, d);
    mo = '{8'h9C, 8'h00, 8'h00, 8'h00};
    miso_exp.push_back(8'h00);
    xfer(mo, 1, 1'b0, 1'b0, 1'b0, "R8 xfer");
    reg_read(2'd1, d); chk("R8 events set", d, 8'h0F);
    reg_read(2'd1, d); chk("R8 events cleared", d, 8'h03);

    // R9 interrupt masking (rx holds one byte, tx free)
    reg_write(2'd0, 8'hE1); waitc(1); chk("R9 rx unmasked", {7'd0, irq}, 8'h01);
    reg_write(2'd0, 8'hF1); waitc(1); chk("R9 all masked", {7'd0, irq}, 8'h00);
    reg_write(2'd0, 8'hD1); waitc(1); chk("R9 tx unmasked", {7'd0, irq}, 8'h01);
    rx_exp.push_back(8'h9C); drain_rx("R9 drain", 1);
    reg_write(2'd0, 8'hE1); waitc(1); chk("R9 rx empty quiet", {7'd0, irq}, 8'h00);
    reg_write(2'd0, 8'h71); waitc(1); chk("R9 no cs event", {7'd0, irq}, 8'h00);
    sck = 1'b0; csn = 1'b0; waitc(H);
    chk("R9 cs low event irq", {7'd0, irq}, 8'h01);
    csn = 1'b1; waitc(H);
    reg_read(2'd1, d);

    // R10 partial byte discarded
    reg_write(2'd0, 8'hF1);
    csn = 1'b0; waitc(H);
    for (int i = 0; i < 4; i++) one_bit(1'b1, 1'b0, 1'b0, m);
    waitc(H); csn = 1'b1; waitc(2 * H);
    mo = '{8'h5A, 8'h00, 8'h00, 8'h00};
    miso_exp.push_back(8'h00); rx_exp.push_back(8'h5A);
    xfer(mo, 1, 1'b0, 1'b0, 1'b0, "R10 xfer");
    drain_rx("R10 only full byte", 2);

    // R7 disabled: bus ignored
    reg_write(2'd0, 8'hF0);
    reg_read(2'd1, d);
    reg_write(2'd2, 8'h99);
    mo = '{8'hE7, 8'h00, 8'h00, 8'h00};
    miso_exp.push_back(8'h00);
    xfer(mo, 1, 1'b0, 1'b0, 1'b0, "R7 miso silent");
    reg_read(2'd1, d); chk("R7 no rx no events", d, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule